// File: doc/BRIEF.md
# NOR Flash Command Interface Model

This block is a synthesizable model of the device side of a single-bank NOR flash. A small word-addressed array is split into equal blocks, each guarded by a lock bit that is set at reset. A host writes 16-bit commands on a simple synchronous bus: one write strobe with an address and write data. It reads back either array contents or a status byte, depending on the last mode-setting command.

Programming and block erase run for a parameterized number of busy cycles. An erase can be suspended to read the array and then resumed. Suspended cycles do not count toward the erase time. The model suits system-level simulation and emulation of flash driver software, where command ordering, polling and suspend handling matter more than analog timing.

Top module: `nor_flash_model`

## Requirements
- R1: After reset every word reads 0xFFFF, the read mode is array, every block is locked and the status byte is 0x80.
- R2: Command low byte 0xFF selects array reads and 0x70 selects status reads, which return {8'h00, status}. Status bit 7 is ready, bit 6 is erase suspended, bit 5 is erase error, bit 4 is program error, bit 1 is lock error, and all other bits are 0.
- R3: Writing 0x60 and then 0xD0 unlocks the block that holds the address of the 0xD0 write. If 0x60 is followed by any other value, the sequence is cancelled and the lock is unchanged. Lock bits never return to 1 after reset.
- R4: Writing 0x40 and then a data word at an address programs that word to old AND data after PROG_CYC busy cycles. Ready reads 0 during those cycles, and reads return status from the 0x40 write onward.
- R5: A program aimed at a locked block leaves the array unchanged, sets bits 4 and 1, and never clears ready.
- R6: Writing 0x20 and then 0xD0 erases the block of the 0xD0 address: after ERASE_CYC busy cycles every word of that block reads 0xFFFF and the other blocks are unchanged. If 0x20 is followed by any other value, the sequence is cancelled without an erase.
- R7: An erase aimed at a locked block leaves the array unchanged and sets bits 5 and 1.
- R8: Command 0x50 clears bits 5, 4 and 1 and leaves ready and suspended as they are.
- R9: 0xB0 written during an erase suspends it: on the next cycle the status reads 0xC0, and array reads of the erasing block still return its old contents.
- R10: 0xD0 written while suspended resumes the erase. Bit 6 clears, ready drops, and the erase ends after the remaining busy cycles, with the suspended time not counted.
- R11: A 0xB0 that arrives in the last busy cycle of an erase has no effect: the erase completes and the status reads 0x80.
- R12: During a program every write is ignored. While suspended, only 0xD0, 0xFF, 0x70 and 0x50 are acted on, so program and erase commands change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one command or data word per cycle |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 16 | Command or program data |
| bus_rdata_o | output | 16 | Array word or status, depending on read mode |

## Verification
The hardest situation to reach from the ports is a suspend request that lands on the exact cycle the erase finishes, because the remaining count is not visible. The bench counts idle cycles from the erase confirm so that the 0xB0 write coincides with the final busy cycle. It does the same after a suspend placed a known number of cycles in, and measures the busy length after resume. Random program traffic over all blocks, checked against a bench array model, covers the AND-only programming rule.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR_ERR   = 8'h50;
  localparam logic [7:0] CMD_PROGRAM     = 8'h40;
  localparam logic [7:0] CMD_ERASE       = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_LOCK_SETUP  = 8'h60;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;

  localparam int unsigned SB_READY    = 7;
  localparam int unsigned SB_SUSP     = 6;
  localparam int unsigned SB_ERA_ERR  = 5;
  localparam int unsigned SB_PRG_ERR  = 4;
  localparam int unsigned SB_LOCK_ERR = 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRG_SETUP, ST_ERA_SETUP, ST_LCK_SETUP,
    ST_PRG_BUSY, ST_ERA_BUSY, ST_ERA_SUSP
  } nor_state_e;
endpackage

// File: rtl/nor_array.sv
module nor_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BLK_W  = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_en_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              erase_en_i,
  input  logic [BLK_W-1:0]  erase_blk_i,
  input  logic              unlock_en_i,
  input  logic [BLK_W-1:0]  unlock_blk_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [(1<<BLK_W)-1:0] lock_o
);
  localparam int unsigned NWORDS = 1 << ADDR_W;
  localparam int unsigned NBLK   = 1 << BLK_W;
  localparam int unsigned OFF_W  = ADDR_W - BLK_W;

  logic [NWORDS-1:0][DATA_W-1:0] words;
  logic [NBLK-1:0]               lock_q;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam logic [BLK_W-1:0]  MY_BLK  = BLK_W'(w >> OFF_W);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(w);
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '1;
      else if (erase_en_i && erase_blk_i == MY_BLK) word_q <= '1;
      else if (prog_en_i && prog_addr_i == MY_ADDR) word_q <= word_q & prog_data_i;
    end
    assign words[w] = word_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= '1;
    else if (unlock_en_i) lock_q[unlock_blk_i] <= 1'b0;
  end

  assign rd_data_o = words[rd_addr_i];
  assign lock_o    = lock_q;
endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             done_o,
  output logic [CNT_W-1:0] remain_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o   = run_i && (cnt_q == CNT_W'(1));
  assign remain_o = cnt_q;
endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_flash_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned BLK_W     = 2,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned PROG_CYC  = 4,
  parameter int unsigned ERASE_CYC = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [15:0]           wdata_i,
  input  logic [(1<<BLK_W)-1:0] lock_i,
  input  logic                  tmr_done_i,
  output logic                  tmr_load_o,
  output logic [CNT_W-1:0]      tmr_val_o,
  output logic                  tmr_run_o,
  output logic                  prog_en_o,
  output logic [ADDR_W-1:0]     prog_addr_o,
  output logic [15:0]           prog_data_o,
  output logic                  erase_en_o,
  output logic [BLK_W-1:0]      erase_blk_o,
  output logic                  unlock_en_o,
  output logic [BLK_W-1:0]      unlock_blk_o,
  output logic [7:0]            status_o,
  output logic                  status_mode_o,
  output nor_state_e            state_o
);
  nor_state_e        state_q, state_d;
  logic              mode_q, mode_d;
  logic              era_err_q, era_err_d, prg_err_q, prg_err_d, lck_err_q, lck_err_d;
  logic [ADDR_W-1:0] op_addr_q, op_addr_d;
  logic [15:0]       op_data_q, op_data_d;

  logic [7:0]       cmd;
  logic [BLK_W-1:0] blk;
  logic             blk_locked;
  assign cmd        = wdata_i[7:0];
  assign blk        = addr_i[ADDR_W-1 -: BLK_W];
  assign blk_locked = lock_i[blk];

  always_comb begin
    state_d     = state_q;
    mode_d      = mode_q;
    era_err_d   = era_err_q;
    prg_err_d   = prg_err_q;
    lck_err_d   = lck_err_q;
    op_addr_d   = op_addr_q;
    op_data_d   = op_data_q;
    tmr_load_o  = 1'b0;
    tmr_val_o   = '0;
    unlock_en_o = 1'b0;
    case (state_q)
      ST_IDLE, ST_ERA_SUSP: if (we_i) begin
        case (cmd)
          CMD_READ_ARRAY:  mode_d = 1'b0;
          CMD_READ_STATUS: mode_d = 1'b1;
          CMD_CLEAR_ERR: begin
            era_err_d = 1'b0; prg_err_d = 1'b0; lck_err_d = 1'b0;
          end
          CMD_PROGRAM: if (state_q == ST_IDLE) begin
            state_d = ST_PRG_SETUP; mode_d = 1'b1;
          end
          CMD_ERASE: if (state_q == ST_IDLE) begin
            state_d = ST_ERA_SETUP; mode_d = 1'b1;
          end
          CMD_LOCK_SETUP: if (state_q == ST_IDLE) state_d = ST_LCK_SETUP;
          CMD_CONFIRM: if (state_q == ST_ERA_SUSP) begin
            state_d = ST_ERA_BUSY; mode_d = 1'b1;
          end
          default: ;
        endcase
      end
      ST_PRG_SETUP: if (we_i) begin
        op_addr_d = addr_i;
        op_data_d = wdata_i;
        if (blk_locked) begin
          prg_err_d = 1'b1; lck_err_d = 1'b1; state_d = ST_IDLE;
        end else begin
          tmr_load_o = 1'b1; tmr_val_o = CNT_W'(PROG_CYC); state_d = ST_PRG_BUSY;
        end
      end
      ST_ERA_SETUP: if (we_i) begin
        state_d = ST_IDLE;
        if (cmd == CMD_CONFIRM) begin
          op_addr_d = addr_i;
          if (blk_locked) begin
            era_err_d = 1'b1; lck_err_d = 1'b1;
          end else begin
            tmr_load_o = 1'b1; tmr_val_o = CNT_W'(ERASE_CYC); state_d = ST_ERA_BUSY;
          end
        end
      end
      ST_LCK_SETUP: if (we_i) begin
        unlock_en_o = (cmd == CMD_CONFIRM);
        state_d     = ST_IDLE;
      end
      ST_PRG_BUSY: if (tmr_done_i) state_d = ST_IDLE;
      ST_ERA_BUSY: begin
        // completion wins over a suspend landing on the final cycle
        if (tmr_done_i) state_d = ST_IDLE;
        else if (we_i && cmd == CMD_SUSPEND) begin
          state_d = ST_ERA_SUSP; mode_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mode_q    <= 1'b0;
      era_err_q <= 1'b0;
      prg_err_q <= 1'b0;
      lck_err_q <= 1'b0;
      op_addr_q <= '0;
      op_data_q <= '0;
    end else begin
      state_q   <= state_d;
      mode_q    <= mode_d;
      era_err_q <= era_err_d;
      prg_err_q <= prg_err_d;
      lck_err_q <= lck_err_d;
      op_addr_q <= op_addr_d;
      op_data_q <= op_data_d;
    end
  end

  logic busy;
  assign busy         = (state_q == ST_PRG_BUSY) || (state_q == ST_ERA_BUSY);
  assign tmr_run_o    = busy;
  assign prog_en_o    = (state_q == ST_PRG_BUSY) && tmr_done_i;
  assign prog_addr_o  = op_addr_q;
  assign prog_data_o  = op_data_q;
  assign erase_en_o   = (state_q == ST_ERA_BUSY) && tmr_done_i;
  assign erase_blk_o  = op_addr_q[ADDR_W-1 -: BLK_W];
  assign unlock_blk_o = blk;

  always_comb begin
    status_o              = '0;
    status_o[SB_READY]    = !busy;
    status_o[SB_SUSP]     = (state_q == ST_ERA_SUSP);
    status_o[SB_ERA_ERR]  = era_err_q;
    status_o[SB_PRG_ERR]  = prg_err_q;
    status_o[SB_LOCK_ERR] = lck_err_q;
  end
  assign status_mode_o = mode_q;
  assign state_o       = state_q;
endmodule

// File: rtl/nor_flash_model.sv
module nor_flash_model
  import nor_flash_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned BLK_W     = 2,
  parameter int unsigned PROG_CYC  = 4,
  parameter int unsigned ERASE_CYC = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [15:0]       bus_wdata_i,
  output logic [15:0]       bus_rdata_o
);
  localparam int unsigned NBLK  = 1 << BLK_W;
  localparam int unsigned MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  logic              tmr_load, tmr_run, tmr_done;
  logic [CNT_W-1:0]  tmr_val, tmr_remain;
  logic              prog_en, erase_en, unlock_en;
  logic [ADDR_W-1:0] prog_addr;
  logic [15:0]       prog_data, arr_rdata;
  logic [BLK_W-1:0]  erase_blk, unlock_blk;
  logic [NBLK-1:0]   blk_lock;
  logic [7:0]        status;
  logic              status_mode;
  nor_state_e        ctrl_state;

  nor_cmd_ctrl #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .CNT_W(CNT_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .lock_i(blk_lock), .tmr_done_i(tmr_done),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .tmr_run_o(tmr_run),
    .prog_en_o(prog_en), .prog_addr_o(prog_addr), .prog_data_o(prog_data),
    .erase_en_o(erase_en), .erase_blk_o(erase_blk),
    .unlock_en_o(unlock_en), .unlock_blk_o(unlock_blk),
    .status_o(status), .status_mode_o(status_mode), .state_o(ctrl_state)
  );

  nor_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni,
    .load_i(tmr_load), .load_val_i(tmr_val), .run_i(tmr_run),
    .done_o(tmr_done), .remain_o(tmr_remain)
  );

  nor_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .DATA_W(16)) u_array (
    .clk_i, .rst_ni,
    .prog_en_i(prog_en), .prog_addr_i(prog_addr), .prog_data_i(prog_data),
    .erase_en_i(erase_en), .erase_blk_i(erase_blk),
    .unlock_en_i(unlock_en), .unlock_blk_i(unlock_blk),
    .rd_addr_i(bus_addr_i), .rd_data_o(arr_rdata), .lock_o(blk_lock)
  );

  assign bus_rdata_o = status_mode ? {8'h00, status} : arr_rdata;
endmodule

// File: rtl/nor_flash_sva.sv
module nor_flash_sva
  import nor_flash_pkg::*;
#(
  parameter int unsigned NBLK  = 4,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input nor_state_e       state_i,
  input logic [CNT_W-1:0] remain_i,
  input logic [NBLK-1:0]  lock_i,
  input logic [7:0]       status_i,
  input logic             mode_i
);
  p_busy_has_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_PRG_BUSY || state_i == ST_ERA_BUSY) |-> remain_i != '0);

  p_start_reads_status_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_i) == ST_PRG_SETUP && state_i == ST_PRG_BUSY) |-> mode_i);

  p_locks_only_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i & ~$past(lock_i)) == '0);

  p_suspend_is_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[SB_SUSP] |-> status_i[SB_READY]);

  p_suspend_from_erase_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_i[SB_SUSP]) |-> $past(state_i) == ST_ERA_BUSY);

  p_suspend_holds_count_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ERA_SUSP && $past(state_i) == ST_ERA_SUSP) |-> remain_i == $past(remain_i));
endmodule

bind nor_flash_model nor_flash_sva #(.NBLK(NBLK), .CNT_W(CNT_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_i(ctrl_state), .remain_i(tmr_remain),
  .lock_i(blk_lock), .status_i(status), .mode_i(status_mode)
);

// File: tb/nor_flash_model_tb.sv
module nor_flash_model_tb;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned BLK_W  = 2;
  localparam int unsigned P_CYC  = 4;
  localparam int unsigned E_CYC  = 12;
  localparam int unsigned NW     = 1 << ADDR_W;
  localparam int unsigned BW     = 1 << (ADDR_W - BLK_W);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       wdata = '0;
  logic [15:0]       rdata;

  int checks = 0;
  int fails  = 0;
  logic [15:0] mdl [NW];

  always #2 clk = ~clk;

  nor_flash_model #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .PROG_CYC(P_CYC), .ERASE_CYC(E_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  function automatic logic [15:0] f_stat(bit rdy, bit sus, bit ee, bit pe, bit le);
    return {8'h00, rdy, sus, ee, pe, 2'b00, le, 1'b0};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [15:0] d);
    we = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic chk_word(string tag, int a, logic [15:0] exp);
    addr = ADDR_W'(a); #1;
    chk(tag, rdata, exp);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (rdata[7] == 1'b0 && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic chk_all(string tag);
    wr(0, 16'h00FF);
    for (int i = 0; i < NW; i++) chk_word(tag, i, mdl[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NW; i++) mdl[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_word("R1 word0", 0, 16'hFFFF);
    chk_word("R1 word37", 37, 16'hFFFF);
    chk_word("R1 word63", 63, 16'hFFFF);
    wr(0, 16'h0070);
    chk("R1 R2 reset status", rdata, f_stat(1, 0, 0, 0, 0));

    // R5 program to locked block
    wr(3, 16'h0040); wr(3, 16'h1234);
    chk("R5 R2 locked program status", rdata, f_stat(1, 0, 0, 1, 1));
    wr(0, 16'h00FF);
    chk_word("R5 array untouched", 3, 16'hFFFF);

    // R7 erase to locked block
    wr(50, 16'h0020); wr(50, 16'h00D0);
    chk("R7 locked erase status", rdata, f_stat(1, 0, 1, 1, 1));
    wr(0, 16'h00FF);
    chk_word("R7 array untouched", 50, 16'hFFFF);

    // R8 clear errors
    wr(0, 16'h0070); wr(0, 16'h0050);
    chk("R8 cleared status", rdata, f_stat(1, 0, 0, 0, 0));

    // R3 cancelled unlock keeps block 1 locked
    wr(16, 16'h0060); wr(16, 16'h0000);
    wr(16, 16'h0040); wr(16, 16'h0F0F);
    chk("R3 cancel keeps lock", rdata, f_stat(1, 0, 0, 1, 1));
    wr(0, 16'h0050);

    // R3 unlock every block via confirm address inside the block
    for (int b = 0; b < (1 << BLK_W); b++) begin
      wr(b * BW, 16'h0060); wr(b * BW + 5, 16'h00D0);
    end

    // R4 program timing and AND behaviour
    wr(3, 16'h0040); wr(3, 16'h1234);
    chk("R4 busy after program", rdata, f_stat(0, 0, 0, 0, 0));
    busy_len(n);
    chk("R4 program busy cycles", 16'(n), 16'(P_CYC));
    chk("R4 ready after program", rdata, f_stat(1, 0, 0, 0, 0));
    wr(0, 16'h00FF); mdl[3] = 16'h1234;
    chk_word("R4 programmed word", 3, 16'h1234);
    wr(3, 16'h0040); wr(3, 16'h00FF); busy_len(n);
    wr(0, 16'h00FF); mdl[3] = 16'h0034;
    chk_word("R4 only clears bits", 3, 16'h0034);

    // R12 writes during program are ignored
    wr(4, 16'h0040); wr(4, 16'hA5A5);
    wr(0, 16'h00FF);
    chk("R12 read mode held while busy", rdata, f_stat(0, 0, 0, 0, 0));
    busy_len(n); mdl[4] = 16'hA5A5;
    wr(0, 16'h00FF);
    chk_word("R12 program intact", 4, 16'hA5A5);

    // R4 random programs against bench model
    for (int it = 0; it < 40; it++) begin
      int a;
      logic [15:0] d;
      a = int'($urandom % NW);
      d = 16'($urandom);
      wr(a, 16'h0040); wr(a, d); busy_len(n);
      mdl[a] = mdl[a] & d;
      if (it % 5 == 4) begin
        int r;
        r = int'($urandom % NW);
        wr(0, 16'h00FF);
        chk_word("R4 random read", r, mdl[r]);
      end
    end
    chk_all("R4 random full array");

    // R6 erase block 2
    wr(32, 16'h0020); wr(40, 16'h00D0);
    busy_len(n);
    chk("R6 erase busy cycles", 16'(n), 16'(E_CYC));
    for (int i = 2 * BW; i < 3 * BW; i++) mdl[i] = 16'hFFFF;
    chk_all("R6 erase block 2 only");

    // R6 cancelled erase
    wr(36, 16'h0040); wr(36, 16'h5A5A); busy_len(n); mdl[36] = 16'h5A5A;
    wr(36, 16'h0020); wr(36, 16'h0070);
    chk("R6 cancel stays ready", rdata, f_stat(1, 0, 0, 0, 0));
    repeat (E_CYC + 2) @(negedge clk);
    wr(0, 16'h00FF);
    chk_word("R6 cancel no erase", 36, 16'h5A5A);

    // R9 suspend, R12 ignore while suspended, R10 resume
    wr(20, 16'h0040); wr(20, 16'h1357); busy_len(n); mdl[20] = mdl[20] & 16'h1357;
    wr(16, 16'h0020); wr(16, 16'h00D0);
    repeat (2) @(negedge clk);
    wr(16, 16'h00B0);
    chk("R9 suspended status", rdata, f_stat(1, 1, 0, 0, 0));
    wr(0, 16'h00FF);
    chk_word("R9 old data readable", 20, mdl[20]);
    wr(5, 16'h0040); wr(5, 16'h0101);
    chk_word("R12 program ignored when suspended", 5, mdl[5]);
    wr(0, 16'h0070);
    chk("R12 still suspended", rdata, f_stat(1, 1, 0, 0, 0));
    wr(16, 16'h00D0);
    chk("R10 resumed busy", rdata, f_stat(0, 0, 0, 0, 0));
    busy_len(n);
    chk("R10 remaining cycles", 16'(n), 16'(E_CYC - 3));
    chk("R10 done status", rdata, f_stat(1, 0, 0, 0, 0));
    for (int i = BW; i < 2 * BW; i++) mdl[i] = 16'hFFFF;
    wr(0, 16'h00FF);
    for (int i = BW; i < 2 * BW; i++) chk_word("R10 block 1 erased", i, 16'hFFFF);

    // R11 suspend on final busy cycle
    wr(0, 16'h0020); wr(0, 16'h00D0);
    repeat (E_CYC - 1) @(negedge clk);
    wr(0, 16'h00B0);
    chk("R11 late suspend dropped", rdata, f_stat(1, 0, 0, 0, 0));
    for (int i = 0; i < BW; i++) mdl[i] = 16'hFFFF;
    chk_all("R11 R6 final array");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule